// File: doc/BRIEF.md
# Processor-Bus to AHB-Lite Master Bridge

This block sits between an older processor core and an AHB-Lite interconnect. On the core side the core raises an active-low request strobe, a sequential flag, an access size, a write flag, write data and an address. That address settles only late in its cycle. The bridge answers with a stall and returns read data. On the bus side it acts as a fully synchronous AHB-Lite master. Every output is timed from the rising edge of the bus clock. The core clock is the inverse of this clock, so core events on the falling edge of the core clock arrive here at rising bus-clock edges.

The core address cannot be trusted early enough to drive the bus in the same cycle. A non-sequential access therefore costs one extra cycle: the core is stalled while the bridge registers the settled address, and the NONSEQ transfer goes out with that registered value in the next cycle. Sequential accesses never look at the core address. The bridge computes the next address itself by adding the transfer size to the last accepted address, so runs of sequential accesses to a zero-wait slave need no extra cycles.

The bridge also moves data between the core and the bus. Write data is registered and spread across the byte lanes. Read data has the addressed lane pulled down to the low bits.

Top module: `cpu_ahb_bridge`

## Requirements
- R1: HTRANS is 2'b00 (IDLE) when the request strobe is high. It is 2'b11 (SEQ) when the strobe is low with the sequential flag set. It is 2'b10 (NONSEQ) when the strobe is low with the flag clear, but only in the cycle after the inserted wait cycle, which itself shows IDLE. BUSY (2'b01) is never driven.
- R2: Each non-sequential access stalls the core for exactly one cycle when HREADY is high.
- R3: During a NONSEQ address phase, HADDR equals the core address registered at the end of the preceding wait cycle.
- R4: During a SEQ address phase, HADDR equals the previously accepted address plus 1, 2 or 4 bytes for a size code of 0, 1 or 2, and the core address input has no effect on it.
- R5: Cycles without a request leave the predicted address unchanged, so a SEQ access after idle cycles continues from the last accepted address plus its size.
- R6: A sequential request with HREADY high is never stalled.
- R7: While HREADY is low, the core is stalled and HADDR, HTRANS, HWRITE, HSIZE and HWDATA keep their values.
- R8: In the cycle after a write's address phase is accepted, HWDATA carries the core write data. A byte (size 0) repeats bits 7:0 on all four lanes, and a halfword (size 1) repeats bits 15:0 on both halves.
- R9: During a read data phase, core read data is the addressed part of HRDATA, zero-extended. The byte at address offset k is taken from bits 8k+7:8k, and a halfword from the half selected by address bit 1.
- R10: While reset is asserted, HTRANS is IDLE, the stall is low and HADDR is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock (the core runs on its inverse) |
| hresetn | input | 1 | Asynchronous reset, active low |
| core_req_n | input | 1 | Core memory request, active low |
| core_seq | input | 1 | Core marks the access as sequential to the previous one |
| core_write | input | 1 | Core access is a write |
| core_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| core_addr | input | AW (32) | Core address, valid only late in the cycle |
| core_wdata | input | DW (32) | Core write data, in the low bits for narrow writes |
| core_rdata | output | DW (32) | Read data returned to the core, lane-aligned |
| core_stall | output | 1 | Holds the core on its current request |
| haddr | output | AW (32) | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write flag |
| hsize | output | 3 | AHB transfer size |
| hwdata | output | DW (32) | AHB write data |
| hrdata | input | DW (32) | AHB read data |
| hready | input | 1 | AHB transfer-done from the slave |

## Verification
A non-sequential write followed by back-to-back sequential writes carries a deliberately wrong value on the core address. This separates an address predicted by the incrementer from one copied off the core bus, and a single inserted stall from none or several. A sequential run of mixed sizes after an idle cycle checks that the predictor holds during idle cycles and steps by the right amount for each size. Byte, halfword and word writes and reads at different offsets of one word check lane replication and lane extraction against the stored memory image. A sequential write issued while the slave holds HREADY low shows that the address phase and the earlier write data stay frozen until the slave releases the bus.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_t;

  // byte count of one transfer for a size code
  function automatic logic [3:0] step_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

endpackage

// File: rtl/bridge_xfer_ctl.sv
module bridge_xfer_ctl
  import bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_n,
  input  logic    seq,
  input  logic    hready,
  output htrans_t trans,
  output logic    stall,
  output logic    wait_cyc,
  output logic    accept
);

  logic addr_held;   // late address already registered for this nonseq

  always_comb begin
    wait_cyc = !req_n && !seq && !addr_held;
    if (req_n)          trans = TR_IDLE;
    else if (seq)       trans = TR_SEQ;
    else if (addr_held) trans = TR_NONSEQ;
    else                trans = TR_IDLE;
    stall  = wait_cyc || !hready;
    accept = (trans != TR_IDLE) && hready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_held <= 1'b0;
    else if (req_n)    addr_held <= 1'b0;
    else if (wait_cyc) addr_held <= 1'b1;
    else if (accept)   addr_held <= 1'b0;
  end

  AST_SINGLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cyc |=> !wait_cyc); // R2

  AST_NONSEQ_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cyc |=> (trans == TR_NONSEQ) || req_n || seq); // R1

  AST_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trans != TR_BUSY); // R1

endmodule

// File: rtl/bridge_addr_pred.sv
module bridge_addr_pred
  import bridge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          accept,
  input  logic [1:0]    size,
  input  logic [AW-1:0] core_addr,
  output logic [AW-1:0] addr
);

  localparam int PAD = AW - 4;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_next;

  always_comb addr_next = addr_q + {{PAD{1'b0}}, step_bytes(size)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= core_addr;
    else if (accept)  addr_q <= addr_next;
  end

  assign addr = addr_q;

  AST_PRED_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !accept |=> $stable(addr)); // R5

endmodule

// File: rtl/bridge_data_lane.sv
module bridge_data_lane #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          hready,
  input  logic          write,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] hrdata,
  output logic [DW-1:0] hwdata,
  output logic [DW-1:0] core_rdata
);

  localparam int NB = DW / 8;
  localparam int LB = (NB > 1) ? $clog2(NB) : 1;

  logic [DW-1:0] wd_q;
  logic [1:0]    dp_size;
  logic [LB-1:0] dp_lo;

  function automatic logic [DW-1:0] spread_lanes(input logic [DW-1:0] w,
                                                 input logic [1:0] sz);
    logic [DW-1:0] r;
    int n;
    n = 1 << sz;
    if (n > NB) n = NB;
    r = '0;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = w[8*(i % n) +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pick_lanes(input logic [DW-1:0] d,
                                               input logic [1:0] sz,
                                               input logic [LB-1:0] lo);
    logic [DW-1:0] r;
    int n;
    int base;
    n = 1 << sz;
    base = int'(lo) & ~(n - 1);
    r = '0;
    for (int i = 0; i < NB; i++)
      if (i < n && (base + i) < NB) r[8*i +: 8] = d[8*(base + i) +: 8];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q    <= '0;
      dp_size <= '0;
      dp_lo   <= '0;
    end else if (accept) begin
      if (write) wd_q <= spread_lanes(core_wdata, size);
      dp_size <= size;
      dp_lo   <= addr[LB-1:0];
    end
  end

  assign hwdata     = wd_q;
  assign core_rdata = pick_lanes(hrdata, dp_size, dp_lo);

  AST_WDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(hwdata)); // R7

  logic unused_hi;
  assign unused_hi = ^addr[AW-1:LB];

endmodule

// File: rtl/cpu_ahb_bridge.sv
module cpu_ahb_bridge
  import bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          core_req_n,
  input  logic          core_seq,
  input  logic          core_write,
  input  logic [1:0]    core_size,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  output logic          core_stall,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready
);

  localparam int PAD = AW - 4;

  htrans_t trans_w;
  logic    wait_w;
  logic    accept_w;

  bridge_xfer_ctl u_ctl (
    .clk      (hclk),
    .rst_n    (hresetn),
    .req_n    (core_req_n),
    .seq      (core_seq),
    .hready   (hready),
    .trans    (trans_w),
    .stall    (core_stall),
    .wait_cyc (wait_w),
    .accept   (accept_w)
  );

  bridge_addr_pred #(.AW(AW)) u_pred (
    .clk       (hclk),
    .rst_n     (hresetn),
    .capture   (wait_w),
    .accept    (accept_w),
    .size      (core_size),
    .core_addr (core_addr),
    .addr      (haddr)
  );

  bridge_data_lane #(.AW(AW), .DW(DW)) u_data (
    .clk        (hclk),
    .rst_n      (hresetn),
    .accept     (accept_w),
    .hready     (hready),
    .write      (core_write),
    .size       (core_size),
    .addr       (haddr),
    .core_wdata (core_wdata),
    .hrdata     (hrdata),
    .hwdata     (hwdata),
    .core_rdata (core_rdata)
  );

  assign htrans = trans_w;
  assign hwrite = core_write;
  assign hsize  = {1'b0, core_size};

  AST_NONSEQ_ADDR: assert property (@(posedge hclk) disable iff (!hresetn)
    $past(wait_w) && (htrans == TR_NONSEQ) |-> haddr == $past(core_addr)); // R3

  AST_SEQ_STEP: assert property (@(posedge hclk) disable iff (!hresetn)
    accept_w |=> (htrans != TR_SEQ) ||
      (haddr == $past(haddr) + {{PAD{1'b0}}, step_bytes($past(hsize[1:0]))})); // R4

  AST_SEQ_NO_STALL: assert property (@(posedge hclk) disable iff (!hresetn)
    !core_req_n && core_seq && hready |-> !core_stall); // R6

  AST_ADDR_PHASE_HELD: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready && (htrans != TR_IDLE) |=> $stable(haddr) && $stable(htrans)
      && $stable(hwrite) && $stable(hsize)); // R7

  AST_STALL_ON_WAIT: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |-> core_stall); // R7

endmodule

// File: tb/sim_cpu_ahb_bridge.sv
module sim_cpu_ahb_bridge;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        core_req_n = 1'b1;
  logic        core_seq = 1'b0;
  logic        core_write = 1'b0;
  logic [1:0]  core_size = 2'd2;
  logic [31:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic [31:0] core_rdata;
  logic        core_stall;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic [31:0] hrdata;
  logic        hready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 hclk = ~hclk;   // 50 MHz

  cpu_ahb_bridge u0 (
    .hclk(hclk), .hresetn(hresetn), .core_req_n(core_req_n), .core_seq(core_seq),
    .core_write(core_write), .core_size(core_size), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_stall(core_stall),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
  );

  // zero-wait slave model with byte-lane writes
  logic [31:0] mem [0:63];
  logic        s_act, s_wr;
  logic [31:0] s_addr;
  logic [1:0]  s_size;

  assign hrdata = mem[s_addr[7:2]];

  always @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      s_act <= 1'b0; s_wr <= 1'b0; s_addr <= '0; s_size <= '0;
    end else if (hready) begin
      if (s_act && s_wr)
        for (int b = 0; b < 4; b++)
          if (b >= (int'(s_addr[1:0]) & ~((1 << s_size) - 1)) &&
              b <  (int'(s_addr[1:0]) & ~((1 << s_size) - 1)) + (1 << s_size))
            mem[s_addr[7:2]][8*b +: 8] <= hwdata[8*b +: 8];
      s_act  <= htrans[1];
      s_wr   <= hwrite;
      s_addr <= haddr;
      s_size <= hsize[1:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one core access; returns stall count, first htrans seen, address and type at acceptance
  task automatic access(input bit sq, input bit wr, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] d,
                        output int stalls, output logic [1:0] first_tr,
                        output logic [31:0] acc_addr, output logic [1:0] acc_tr);
    @(negedge hclk);
    core_req_n = 1'b0; core_seq = sq; core_write = wr; core_size = sz;
    core_addr = a; core_wdata = d;
    #5;
    stalls = 0;
    first_tr = htrans;
    while (core_stall) begin
      stalls++;
      @(negedge hclk);
      #5;
    end
    acc_addr = haddr;
    acc_tr = htrans;
  endtask

  task automatic idle_cycle();
    @(negedge hclk);
    core_req_n = 1'b1; core_seq = 1'b0; core_write = 1'b0;
    core_addr = 32'hFFFF_FFF0;
    #5;
  endtask

  task automatic t_reset();
    #5;
    chk(htrans == 2'b00, "R10 htrans in reset", {30'd0, htrans}, 32'd0);
    chk(core_stall == 1'b0, "R10 stall in reset", {31'd0, core_stall}, 32'd0);
    chk(haddr == 32'd0, "R10 haddr in reset", haddr, 32'd0);
    repeat (2) @(posedge hclk);
    @(negedge hclk);
    hresetn = 1'b1;
    idle_cycle();
    chk(htrans == 2'b00, "R1 idle without request", {30'd0, htrans}, 32'd0);
    chk(core_stall == 1'b0, "R1 no stall when idle", {31'd0, core_stall}, 32'd0);
  endtask

  task automatic t_nonseq_then_seq();
    int st; logic [1:0] ft, at; logic [31:0] aa;
    access(1'b0, 1'b1, 2'd2, 32'h0000_0100, 32'hDEAD_BEEF, st, ft, aa, at);
    chk(st == 1, "R2 one stall for nonseq", st, 1);
    chk(ft == 2'b00, "R1 wait cycle shows IDLE", {30'd0, ft}, 32'd0);
    chk(at == 2'b10, "R1 NONSEQ after wait", {30'd0, at}, 32'd2);
    chk(aa == 32'h100, "R3 nonseq address", aa, 32'h100);
    for (int k = 1; k <= 3; k++) begin
      access(1'b1, 1'b1, 2'd2, 32'hBAD0_0000 + k, 32'h1000_0000 + k, st, ft, aa, at);
      chk(st == 0, "R6 no stall for seq", st, 0);
      chk(at == 2'b11, "R1 SEQ transfer type", {30'd0, at}, 32'd3);
      chk(aa == 32'h100 + 4 * k, "R4 predicted word address", aa, 32'h100 + 4 * k);
    end
    idle_cycle();
    chk(hwdata == 32'h1000_0003, "R8 last seq write data", hwdata, 32'h1000_0003);
  endtask

  task automatic t_idle_hold();
    int st; logic [1:0] ft, at; logic [31:0] aa;
    idle_cycle();
    access(1'b1, 1'b0, 2'd1, 32'h0BAD_0BAD, 32'd0, st, ft, aa, at);
    chk(aa == 32'h110, "R5 seq after idle continues", aa, 32'h110);
    access(1'b1, 1'b0, 2'd0, 32'h0BAD_0BAD, 32'd0, st, ft, aa, at);
    chk(aa == 32'h112, "R4 halfword step", aa, 32'h112);
    access(1'b1, 1'b0, 2'd0, 32'h0BAD_0BAD, 32'd0, st, ft, aa, at);
    chk(aa == 32'h113, "R4 byte step", aa, 32'h113);
    chk(st == 0, "R6 seq byte no stall", st, 0);
    idle_cycle();
  endtask

  task automatic t_lanes();
    int st; logic [1:0] ft, at; logic [31:0] aa;
    access(1'b0, 1'b1, 2'd2, 32'h40, 32'h1122_3344, st, ft, aa, at);
    idle_cycle();
    chk(hwdata == 32'h1122_3344, "R8 word write data", hwdata, 32'h1122_3344);
    access(1'b0, 1'b0, 2'd0, 32'h41, 32'd0, st, ft, aa, at);
    idle_cycle();
    chk(core_rdata == 32'h33, "R9 byte read lane 1", core_rdata, 32'h33);
    access(1'b0, 1'b0, 2'd1, 32'h42, 32'd0, st, ft, aa, at);
    idle_cycle();
    chk(core_rdata == 32'h1122, "R9 upper halfword read", core_rdata, 32'h1122);
    access(1'b0, 1'b1, 2'd0, 32'h43, 32'h0000_00AB, st, ft, aa, at);
    idle_cycle();
    chk(hwdata == 32'hABAB_ABAB, "R8 byte replicated", hwdata, 32'hABAB_ABAB);
    access(1'b0, 1'b1, 2'd1, 32'h44, 32'h0000_5566, st, ft, aa, at);
    idle_cycle();
    chk(hwdata == 32'h5566_5566, "R8 halfword replicated", hwdata, 32'h5566_5566);
    access(1'b0, 1'b0, 2'd2, 32'h40, 32'd0, st, ft, aa, at);
    idle_cycle();
    chk(core_rdata == 32'hAB22_3344, "R9 word read after byte write",
        core_rdata, 32'hAB22_3344);
  endtask

  task automatic t_wait_states();
    int st; logic [1:0] ft, at; logic [31:0] aa;
    access(1'b0, 1'b1, 2'd2, 32'h80, 32'hCAFE_F00D, st, ft, aa, at);
    @(negedge hclk);
    core_req_n = 1'b0; core_seq = 1'b1; core_write = 1'b1; core_size = 2'd2;
    core_addr = 32'h5555_5555; core_wdata = 32'h0BAD_BEEF; hready = 1'b0;
    #5;
    chk(core_stall == 1'b1, "R7 stall while not ready", {31'd0, core_stall}, 32'd1);
    chk(haddr == 32'h84, "R7 address during wait", haddr, 32'h84);
    chk(hwdata == 32'hCAFE_F00D, "R7 write data during wait", hwdata, 32'hCAFE_F00D);
    @(negedge hclk);
    #5;
    chk(haddr == 32'h84 && htrans == 2'b11, "R7 address phase still held",
        haddr, 32'h84);
    chk(hwdata == 32'hCAFE_F00D, "R7 write data still held", hwdata, 32'hCAFE_F00D);
    @(negedge hclk);
    hready = 1'b1;
    #5;
    chk(core_stall == 1'b0, "R6 released when ready", {31'd0, core_stall}, 32'd0);
    idle_cycle();
    chk(hwdata == 32'h0BAD_BEEF, "R8 data after wait", hwdata, 32'h0BAD_BEEF);
    access(1'b0, 1'b0, 2'd2, 32'h80, 32'd0, st, ft, aa, at);
    idle_cycle();
    chk(core_rdata == 32'hCAFE_F00D, "R9 write survived wait", core_rdata, 32'hCAFE_F00D);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    t_reset();
    t_nonseq_then_seq();
    t_idle_hold();
    t_lanes();
    t_wait_states();
    idle_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge hclk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule